// File: doc/BRIEF.md
# I2C Target Controller with Host-Released Clock Stretching

This block is the target (slave) side of an I2C link with a fixed 7-bit address. It watches the open-drain SDA and SCL lines through synchronisers and finds START and STOP conditions. It shifts in the address byte and acknowledges it only when the address matches. At defined points in a transfer it pulls SCL low and keeps it low until a local host gives a one-cycle release strobe. This gives the host as much time as it needs to consume a received byte or to supply the next byte to send.

The host sees a received-byte register, the read/write bit of the last matched address, a level that shows the block is stretching, and a one-cycle event strobe with a 2-bit code. The host supplies the next byte to transmit on `tx_data`. The block samples that value when the host releases a stretch, or on the ninth falling SCL edge when stretching after data bytes is turned off. Two options select where data-byte stretching happens. One stretches after the ACK cycle. The other holds SCL after the eighth bit of a received byte and drives the ACK only after the host releases.

The states are named `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_HOLD`, `ST_RX`, `ST_RX_HOLD`, `ST_RX_ACK`, `ST_TX` and `ST_TX_ACK`. The transitions, all taken on a synchronised SCL edge unless noted, are:
- ADDR→ADDR_ACK on the eighth falling edge when the address matches; ADDR→IDLE on that edge when it does not.
- ADDR_ACK→HOLD on the ninth falling edge.
- HOLD→TX (read) or HOLD→RX (write) on the release strobe.
- RX→RX_HOLD (ACK-hold option on) or RX→RX_ACK on the eighth falling edge.
- RX_HOLD→RX_ACK on the release strobe.
- RX_ACK→HOLD (stretch option on) or RX_ACK→RX on the ninth falling edge.
- TX→TX_ACK on the eighth falling edge.
- TX_ACK→IDLE after a NACK; otherwise TX_ACK→HOLD (stretch option on) or TX_ACK→TX.
- Any state→ADDR on a START; any state→IDLE on a STOP.

Top module: `i2c_stretch_target`

## Requirements
- R1: After reset, neither line is pulled low, `stretch_o` is 0 and no event is raised.
- R2: When a START is followed by an address byte whose upper 7 bits equal `TGT_ADDR`, SDA is pulled low during the ninth clock. At the ninth falling edge SCL is then held low, event code 0 is raised and `rw_flag` shows bit 0 of the address byte (1 = read). A non-matching address gets no ACK, no stretch and no event.
- R3: Once held, SCL stays pulled low until `hold_release` is high, and `scl_oe` drops in the same cycle that `hold_release` is seen.
- R4: In a write transfer each data byte is ACKed and appears on `rx_data` with event code 1, raised at the eighth falling SCL edge.
- R5: In a read transfer the byte on `tx_data` when the host releases the hold is sent MSB first. After the controller ACKs a byte, event code 2 is raised and the next byte is taken from `tx_data`.
- R6: With `stretch_en` set, SCL is held after the ACK cycle of every data byte. With it clear, only the address match stretches.
- R7: With `ack_hold_en` set, SCL is held after the eighth bit of a received byte with SDA released. The ACK is driven only after the release.
- R8: A STOP during a transfer raises event code 3. A NACK from the controller after a read byte also raises event code 3, and the block releases SDA and returns to idle.
- R9: A START at any point, including in the middle of a byte, restarts address reception.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| stretch_en | input | 1 | Stretch after the ACK cycle of data bytes |
| ack_hold_en | input | 1 | Stretch before the ACK of received bytes |
| hold_release | input | 1 | Host strobe that ends a stretch |
| tx_data | input | 8 | Next byte to transmit |
| rx_data | output | 8 | Last received data byte |
| rw_flag | output | 1 | Direction bit of the last matched address |
| stretch_o | output | 1 | High while the block holds SCL |
| evt_valid | output | 1 | One-cycle event strobe |
| evt_code | output | 2 | 0 address match, 1 byte received, 2 next byte wanted, 3 transfer end |

## Verification
The hardest case to reach is the hold before the ACK. The bench has to prove that SDA is still released while SCL is held after the eighth bit, and that the ACK then shows up in the ninth clock. To do this, the bench controller marks the last bit of the data byte before it clocks it out. The host model then looks at the bus lines at that moment, before it gives the release. A START in the middle of a byte is reached by stopping a write after four data bits and issuing a repeated START with a read address. The bench then checks that the new address is acknowledged and that the read data comes out correctly.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HOLD,
        ST_RX,
        ST_RX_HOLD,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } tgt_state_e;

    typedef enum logic [1:0] {
        EV_ADDR  = 2'd0,
        EV_RX    = 2'd1,
        EV_TXREQ = 2'd2,
        EV_DONE  = 2'd3
    } tgt_evt_e;

endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff, sda_ff;
    logic              scl_d, sda_d;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_d  <= scl_ff[STAGES-1];
            sda_d  <= sda_ff[STAGES-1];
        end
    end

    assign scl_now   = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_now & ~scl_d;
    assign scl_fall  = ~scl_now & scl_d;
    assign start_det = scl_now & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_now & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2ct_shift.sv
module i2ct_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_val,
    input  logic         sh_in,
    input  logic         sh_out,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (load)   q <= ld_val;
        else if (sh_in)  q <= {q[W-2:0], bit_in};
        else if (sh_out) q <= {q[W-2:0], 1'b0};
    end
endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target
    import i2ct_pkg::*;
#(
    parameter int                ADDR_W      = 7,
    parameter logic [ADDR_W-1:0] TGT_ADDR    = 7'h2A,
    parameter int                SYNC_STAGES = 2,
    localparam int               DATA_W      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              stretch_en,
    input  logic              ack_hold_en,
    input  logic              hold_release,
    input  logic [DATA_W-1:0] tx_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              rw_flag,
    output logic              stretch_o,
    output logic              evt_valid,
    output logic [1:0]        evt_code
);
    localparam int              CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    tgt_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sh_q;
    logic              nack_q;
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              byte_end, sh_load, sh_in, sh_out, counting;

    i2ct_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign byte_end = scl_fall && (cnt_q == LAST_BIT);
    assign counting = (state_q == ST_ADDR) || (state_q == ST_RX) || (state_q == ST_TX);

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (start_det)      state_d = ST_ADDR;
        else if (stop_det)  state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_end)
                                 state_d = (sh_q[DATA_W-1:1] == TGT_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) state_d = ST_HOLD;
                ST_HOLD:     if (hold_release) state_d = rw_flag ? ST_TX : ST_RX;
                ST_RX:       if (byte_end) state_d = ack_hold_en ? ST_RX_HOLD : ST_RX_ACK;
                ST_RX_HOLD:  if (hold_release) state_d = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) state_d = stretch_en ? ST_HOLD : ST_RX;
                ST_TX:       if (byte_end) state_d = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall)
                                 state_d = nack_q ? ST_IDLE : (stretch_en ? ST_HOLD : ST_TX);
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (start_det || state_d != state_q) cnt_q <= '0;
        else if (scl_rise && counting)           cnt_q <= cnt_q + 1'b1;
    end

    assign sh_load = (state_q == ST_HOLD && hold_release && rw_flag)
                   || (state_q == ST_TX_ACK && state_d == ST_TX);
    assign sh_in   = scl_rise && (state_q == ST_ADDR || state_q == ST_RX);
    assign sh_out  = scl_fall && (state_q == ST_TX);

    i2ct_shift #(.W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(sh_load), .ld_val(tx_data),
        .sh_in(sh_in), .sh_out(sh_out), .bit_in(sda_s), .q(sh_q)
    );

    // registered host-side outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_code  <= EV_ADDR;
            rx_data   <= '0;
            rw_flag   <= 1'b0;
            nack_q    <= 1'b0;
        end else begin
            evt_valid <= 1'b0;
            if (!start_det) begin
                if (stop_det) begin
                    if (state_q != ST_IDLE) begin
                        evt_valid <= 1'b1;
                        evt_code  <= EV_DONE;
                    end
                end else begin
                    case (state_q)
                        ST_ADDR: if (state_d == ST_ADDR_ACK) rw_flag <= sh_q[0];
                        ST_ADDR_ACK: if (scl_fall) begin
                            evt_valid <= 1'b1;
                            evt_code  <= EV_ADDR;
                        end
                        ST_RX: if (byte_end) begin
                            rx_data   <= sh_q;
                            evt_valid <= 1'b1;
                            evt_code  <= EV_RX;
                        end
                        ST_TX_ACK: begin
                            if (scl_rise) nack_q <= sda_s;
                            if (scl_fall) begin
                                evt_valid <= 1'b1;
                                evt_code  <= nack_q ? EV_DONE : EV_TXREQ;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // line drives
    assign stretch_o = (state_q == ST_HOLD) || (state_q == ST_RX_HOLD);
    assign scl_oe    = stretch_o && !hold_release;
    assign sda_oe    = (state_q == ST_ADDR_ACK)
                    || (state_q == ST_RX_ACK)
                    || (state_q == ST_RX_HOLD && hold_release)
                    || (state_q == ST_TX && !sh_q[DATA_W-1])
                    || (state_q == ST_HOLD && hold_release && rw_flag && !tx_data[DATA_W-1]);

endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk
    import i2ct_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       stretch_o,
    input logic       hold_release,
    input logic       ack_hold_en,
    input logic       evt_valid,
    input logic [1:0] evt_code
);
    // R2
    addr_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_ADDR) |-> stretch_o);

    // R3
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_o && !hold_release) |=> stretch_o);

    // R3
    stretch_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !$past(scl_i));

    // R7
    preack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == EV_RX && ack_hold_en) |-> stretch_o);

    // R10
    sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_i));
endmodule

bind i2c_stretch_target i2ct_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .stretch_o(stretch_o), .hold_release(hold_release), .ack_hold_en(ack_hold_en),
    .evt_valid(evt_valid), .evt_code(evt_code)
);

// File: tb/i2c_stretch_target_tb_top.sv
module i2c_stretch_target_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n;
    logic       m_scl = 1'b0, m_sda = 1'b0;   // 1 = controller pulls low
    logic       stretch_en, ack_hold_en, hold_release;
    logic [7:0] tx_data;
    logic       scl_oe, sda_oe, rw_flag, stretch_o, evt_valid;
    logic [7:0] rx_data;
    logic [1:0] evt_code;
    logic       scl_line, sda_line;

    assign scl_line = !(m_scl || scl_oe);
    assign sda_line = !(m_sda || sda_oe);

    i2c_stretch_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .stretch_en(stretch_en),
        .ack_hold_en(ack_hold_en), .hold_release(hold_release), .tx_data(tx_data),
        .rx_data(rx_data), .rw_flag(rw_flag), .stretch_o(stretch_o),
        .evt_valid(evt_valid), .evt_code(evt_code)
    );

    int checks = 0, fails = 0, n_stretch = 0;
    int eq_code[$], eq_val[$];
    logic [7:0] tx_q[$];
    bit preack_expect = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_evt(input int code, input int val);
        eq_code.push_back(code);
        eq_val.push_back(val);
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        m_scl = 1'b0;
        while (!scl_line) @(negedge clk);
    endtask

    task automatic i_start();
        m_sda = 1'b1; wait_c(8); m_scl = 1'b1; wait_c(8);
    endtask

    task automatic i_rstart();
        m_sda = 1'b0; wait_c(4); scl_up(); wait_c(8);
        m_sda = 1'b1; wait_c(8); m_scl = 1'b1; wait_c(8);
    endtask

    task automatic i_stop();
        m_sda = 1'b1; wait_c(4); scl_up(); wait_c(8); m_sda = 1'b0; wait_c(8);
    endtask

    task automatic put_bit(input bit b);
        m_sda = !b; wait_c(4); scl_up(); wait_c(8); m_scl = 1'b1; wait_c(4);
    endtask

    task automatic get_bit(output bit b);
        m_sda = 1'b0; wait_c(4); scl_up(); wait_c(2);
        b = sda_line;
        wait_c(4);
        // R10: SDA steady while SCL high
        chk(sda_line == b, "R10", "sda moved while scl high", sda_line, b);
        wait_c(2); m_scl = 1'b1; wait_c(4);
    endtask

    task automatic write_byte(input logic [7:0] v, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask

    task automatic read_byte(output logic [7:0] v, input bit give_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!give_ack);
    endtask

    // host model: answers every stretch
    initial begin
        hold_release = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && scl_oe) begin
                n_stretch++;
                repeat (20) @(negedge clk);
                chk(!scl_line, "R3", "scl not held during stretch", scl_line, 0);
                if (preack_expect) begin
                    chk(sda_line, "R7", "ack driven before release", sda_line, 1);
                    preack_expect = 1'b0;
                end
                if (tx_q.size() != 0) tx_data = tx_q.pop_front();
                @(negedge clk);
                hold_release = 1'b1;
                #1;
                chk(!scl_oe, "R3", "scl_oe not dropped with release", scl_oe, 0);
                @(negedge clk);
                hold_release = 1'b0;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        int c, v;
        if (rst_n && evt_valid) begin
            if (eq_code.size() == 0) begin
                chk(1'b0, "R4", "unexpected event", evt_code, -1);
            end else begin
                c = eq_code.pop_front();
                v = eq_val.pop_front();
                chk(evt_code == c, (c == 0) ? "R2" : (c == 1) ? "R4" : (c == 2) ? "R5" : "R8",
                    "event code", evt_code, c);
                if (c == 0) chk(rw_flag == v, "R2", "rw_flag", rw_flag, v);
                if (c == 1) chk(rx_data == v, "R4", "rx_data", rx_data, v);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog run did not finish actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit ack, b;
        logic [7:0] v;
        int s0;
        rst_n = 1'b0; stretch_en = 1'b1; ack_hold_en = 1'b0; tx_data = 8'h00;
        wait_c(5); rst_n = 1'b1; wait_c(3);

        // R1 reset state
        chk(!scl_oe && !sda_oe, "R1", "line drive after reset", {scl_oe, sda_oe}, 0);
        chk(!stretch_o && !evt_valid, "R1", "status after reset", {stretch_o, evt_valid}, 0);

        // write with stretch after ACK (R2 R4 R6 R8)
        expect_evt(0, 0); expect_evt(1, 8'hA5); expect_evt(1, 8'h3C); expect_evt(3, 0);
        s0 = n_stretch;
        i_start();
        write_byte({7'h2A, 1'b0}, ack); chk(ack, "R2", "address ack", ack, 1);
        write_byte(8'hA5, ack);         chk(ack, "R4", "data ack", ack, 1);
        write_byte(8'h3C, ack);         chk(ack, "R4", "data ack", ack, 1);
        i_stop(); wait_c(10);
        chk(n_stretch - s0 == 3, "R6", "stretch count with stretch_en", n_stretch - s0, 3);

        // address mismatch (R2)
        s0 = n_stretch;
        i_start();
        write_byte({7'h15, 1'b0}, ack); chk(!ack, "R2", "mismatch acked", ack, 0);
        i_stop(); wait_c(10);
        chk(n_stretch == s0, "R2", "stretch on mismatch", n_stretch - s0, 0);

        // read (R5 R8)
        tx_q.push_back(8'h96); tx_q.push_back(8'h5B);
        expect_evt(0, 1); expect_evt(2, 0); expect_evt(3, 0);
        i_start();
        write_byte({7'h2A, 1'b1}, ack); chk(ack, "R2", "read address ack", ack, 1);
        read_byte(v, 1'b1); chk(v == 8'h96, "R5", "first read byte", v, 8'h96);
        read_byte(v, 1'b0); chk(v == 8'h5B, "R5", "second read byte", v, 8'h5B);
        wait_c(6);
        chk(!sda_oe && !stretch_o, "R8", "sda/scl released after nack", {sda_oe, stretch_o}, 0);
        i_stop(); wait_c(10);

        // ack held until release (R7)
        stretch_en = 1'b0; ack_hold_en = 1'b1;
        expect_evt(0, 0); expect_evt(1, 8'h4E); expect_evt(3, 0);
        s0 = n_stretch;
        i_start();
        write_byte({7'h2A, 1'b0}, ack);
        for (int i = 7; i >= 1; i--) put_bit(v_bit(8'h4E, i));
        preack_expect = 1'b1;
        put_bit(1'b0);
        get_bit(b); chk(!b, "R7", "ack after release", b, 0);
        i_stop(); wait_c(10);
        chk(n_stretch - s0 == 2, "R7", "stretch count in ack-hold", n_stretch - s0, 2);
        ack_hold_en = 1'b0;

        // no data stretch (R6)
        expect_evt(0, 0); expect_evt(1, 8'h81); expect_evt(1, 8'h7E); expect_evt(3, 0);
        s0 = n_stretch;
        i_start();
        write_byte({7'h2A, 1'b0}, ack);
        write_byte(8'h81, ack); chk(ack, "R4", "data ack no-stretch", ack, 1);
        write_byte(8'h7E, ack);
        i_stop(); wait_c(10);
        chk(n_stretch - s0 == 1, "R6", "stretch count without stretch_en", n_stretch - s0, 1);

        // repeated start mid-byte (R9)
        stretch_en = 1'b1;
        tx_q.push_back(8'hC3);
        expect_evt(0, 0); expect_evt(0, 1); expect_evt(3, 0);
        i_start();
        write_byte({7'h2A, 1'b0}, ack);
        for (int i = 0; i < 4; i++) put_bit(i[0]);
        i_rstart();
        write_byte({7'h2A, 1'b1}, ack); chk(ack, "R9", "address after restart", ack, 1);
        read_byte(v, 1'b0); chk(v == 8'hC3, "R9", "read after restart", v, 8'hC3);
        i_stop(); wait_c(20);

        chk(eq_code.size() == 0, "R4", "events missing", eq_code.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic bit v_bit(input logic [7:0] v, input int i);
        return v[i];
    endfunction

endmodule